// File: doc/BRIEF.md
# Packet-Granular Coarse Delay Line

This block delays a wideband sample stream by a whole number of packets. On every clock it takes one packet of sixteen 2-bit samples and writes it into a circular RAM whose write pointer advances by one each cycle. A read pointer trails the write pointer by the applied delay, so the stored packet is read back and presented as sixteen parallel 2-bit lanes. No shifting datapath is involved. The delay is set only by the distance between the two pointers.

A new delay request is latched as pending when the load strobe is seen. It is applied only on the next synchronisation pulse, so that many such blocks in a system can change delay together. Requests outside the usable range are clamped and flagged. After reset, and after a jump to a larger delay, the output is marked invalid until the read position reaches packets that were actually written.

Top module: `pkt_delay_line`

## Requirements
- R1: A packet presented on `in_pkt` before clock edge e appears on `out_pkt` after edge e+D+1, where D is the applied delay (`cur_dly`) used by the read at edge e+D. Sample k of a packet sits in bits [2k+1:2k] of both `in_pkt` and `out_pkt`.
- R2: A value loaded with `dly_load` becomes pending. `cur_dly` does not change until an edge at which `sync_pulse` is high, and at that edge it takes the pending value.
- R3: A `sync_pulse` with no pending value leaves `cur_dly` unchanged.
- R4: A request greater than DEPTH-2 is clamped to DEPTH-2. A request of 0 is clamped to 1. Either case sets `range_err` after the loading edge.
- R5: A load with a request in 1..DEPTH-2 clears `range_err`. `range_err` changes only on a load.
- R6: `out_valid` is 0 when the packet read at edge e has index e-D < 0, counting packets written since reset from 0. It is 1 otherwise, with the same one-edge output lag as the data.
- R7: While and right after reset, `out_valid` and `range_err` are 0, `cur_dly` equals INIT_DLY (default 1), and nothing is pending.
- R8: When a load and a sync arrive at the same edge, the value pending before that edge is applied. The new value stays pending until a later sync.
- R9: After `cur_dly` changes at a sync edge s, reads from edge s+1 onward use the new offset. Their data reaches `out_pkt` after edge s+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Packet clock, one packet per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_pkt | input | LANES*SBITS | Incoming packet, sample k in bits [2k+1:2k] |
| dly_load | input | 1 | Strobe that latches `dly_req` as the pending delay |
| dly_req | input | REQ_W | Requested delay in packets |
| sync_pulse | input | 1 | Timing pulse that applies the pending delay |
| out_pkt | output | LANES*SBITS | Delayed packet as sixteen 2-bit lanes |
| out_valid | output | 1 | Output lanes carry written data |
| cur_dly | output | ADDR_W | Delay currently applied, in packets |
| range_err | output | 1 | Last loaded request was out of range and clamped |

## Verification
If the read pointer drifts from the write pointer by the wrong amount, every compared output packet after the next read is wrong. A pseudo-random payload makes such an error show within two cycles of the drift. If the pending register is applied early or lost, `cur_dly` differs from the scripted value at the edge after the load or the sync. The packet offset is then wrong two edges after the sync. A fill tracker that is wrong shows as `out_valid` asserted on never-written packets, or held low on written ones, in the first cycles after reset or after a jump to the maximum delay.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
  localparam int unsigned MIN_DLY = 1;

  function automatic bit dly_bad(input int unsigned req, input int unsigned maxd);
    return (req < MIN_DLY) || (req > maxd);
  endfunction
endpackage

// File: rtl/pdl_ram.sv
module pdl_ram #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  // simple dual port, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pdl_ptr.sv
module pdl_ptr #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cur_dly,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          rd_ok
);
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] wp_q;
  logic [AW:0]   fill_q;   // packets written since reset, saturating

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q   <= '0;
      fill_q <= '0;
    end else begin
      wp_q <= wp_q + 1'b1;
      if (fill_q != (AW+1)'(DEPTH)) fill_q <= fill_q + 1'b1;
    end
  end

  assign waddr = wp_q;
  assign raddr = wp_q - cur_dly;            // wraps modulo DEPTH
  assign rd_ok = fill_q >= {1'b0, cur_dly}; // target packet already written
endmodule

// File: rtl/pdl_ctrl.sv
module pdl_ctrl
  import pdl_pkg::*;
#(
  parameter int AW       = 12,
  parameter int RW       = 14,
  parameter int INIT_DLY = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [RW-1:0] req,
  input  logic          sync,
  output logic [AW-1:0] cur_dly,
  output logic          range_err
);
  localparam int unsigned MAXD = (1 << AW) - 2;

  logic [AW-1:0] pend_q, cur_q, clamped;
  logic          pend_v_q, err_q, bad, over;

  assign bad  = dly_bad(int'(req), MAXD);
  assign over = req > RW'(MAXD);

  always_comb begin
    if (over)     clamped = AW'(MAXD);
    else if (bad) clamped = AW'(MIN_DLY);
    else          clamped = req[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= AW'(INIT_DLY);
      pend_q   <= AW'(INIT_DLY);
      pend_v_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (sync && pend_v_q) cur_q <= pend_q;
      if (load) begin
        pend_q   <= clamped;
        pend_v_q <= 1'b1;
        err_q    <= bad;
      end else if (sync) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  assign cur_dly   = cur_q;
  assign range_err = err_q;
endmodule

// File: rtl/pkt_delay_line.sv
module pkt_delay_line #(
  parameter int LANES    = 16,
  parameter int SBITS    = 2,
  parameter int ADDR_W   = 12,
  parameter int REQ_W    = 14,
  parameter int INIT_DLY = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES*SBITS-1:0] in_pkt,
  input  logic                   dly_load,
  input  logic [REQ_W-1:0]       dly_req,
  input  logic                   sync_pulse,
  output logic [LANES*SBITS-1:0] out_pkt,
  output logic                   out_valid,
  output logic [ADDR_W-1:0]      cur_dly,
  output logic                   range_err
);
  localparam int DW = LANES * SBITS;

  logic [ADDR_W-1:0] waddr, raddr;
  logic              rd_ok, rd_ok_q;
  logic [DW-1:0]     ram_q;

  pdl_ctrl #(.AW(ADDR_W), .RW(REQ_W), .INIT_DLY(INIT_DLY)) u_ctrl (
    .clk(clk), .rst(rst), .load(dly_load), .req(dly_req), .sync(sync_pulse),
    .cur_dly(cur_dly), .range_err(range_err)
  );

  pdl_ptr #(.AW(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .cur_dly(cur_dly),
    .waddr(waddr), .raddr(raddr), .rd_ok(rd_ok)
  );

  pdl_ram #(.AW(ADDR_W), .DW(DW)) u_ram (
    .clk(clk), .we(!rst), .waddr(waddr), .wdata(in_pkt),
    .raddr(raddr), .rdata(ram_q)
  );

  // validity travels alongside the RAM read register
  always_ff @(posedge clk) begin
    if (rst) rd_ok_q <= 1'b0;
    else     rd_ok_q <= rd_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= rd_ok_q;
  end

  // one output register per lane
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) out_pkt[k*SBITS +: SBITS] <= '0;
      else     out_pkt[k*SBITS +: SBITS] <= ram_q[k*SBITS +: SBITS];
    end
  end
endmodule

// File: rtl/pdl_checker.sv
module pdl_checker #(
  parameter int AW = 12,
  parameter int RW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          dly_load,
  input logic [RW-1:0] dly_req,
  input logic          sync_pulse,
  input logic [AW-1:0] cur_dly,
  input logic          range_err,
  input logic          out_valid
);
  localparam int unsigned MAXD = (1 << AW) - 2;

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !sync_pulse |=> $stable(cur_dly));

  p_range_r4: assert property (@(posedge clk) disable iff (rst)
    (cur_dly >= AW'(1)) && (cur_dly <= AW'(MAXD)));

  p_err_set_r4: assert property (@(posedge clk) disable iff (rst)
    dly_load && ((dly_req > RW'(MAXD)) || (dly_req == '0)) |=> range_err);

  p_err_clr_r5: assert property (@(posedge clk) disable iff (rst)
    dly_load && (dly_req <= RW'(MAXD)) && (dly_req != '0) |=> !range_err);

  p_err_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !dly_load |=> $stable(range_err));

  p_start_invalid_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst <= 2'd2) |-> !out_valid);
endmodule

bind pkt_delay_line pdl_checker #(.AW(ADDR_W), .RW(REQ_W)) u_chk (
  .clk(clk), .rst(rst), .dly_load(dly_load), .dly_req(dly_req),
  .sync_pulse(sync_pulse), .cur_dly(cur_dly), .range_err(range_err),
  .out_valid(out_valid)
);

// File: tb/test_pkt_delay_line.sv
module test_pkt_delay_line;
  localparam int CLK_PERIOD = 4;
  localparam int AW = 6;
  localparam int RW = 8;
  localparam int MAXD = (1 << AW) - 2;

  logic          clk = 0;
  logic          rst = 1;
  logic [31:0]   in_pkt = '0;
  logic          dly_load = 0;
  logic [RW-1:0] dly_req = '0;
  logic          sync_pulse = 0;
  logic [31:0]   out_pkt;
  logic          out_valid;
  logic [AW-1:0] cur_dly;
  logic          range_err;

  int compared = 0, mismatched = 0;
  string sb_tag = "R1";
  int pat_mode = 0;
  int gen_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_delay_line #(.ADDR_W(AW), .REQ_W(RW)) i_pkt_delay_line (
    .clk(clk), .rst(rst), .in_pkt(in_pkt), .dly_load(dly_load),
    .dly_req(dly_req), .sync_pulse(sync_pulse), .out_pkt(out_pkt),
    .out_valid(out_valid), .cur_dly(cur_dly), .range_err(range_err)
  );

  // stimulus generator for the packet stream
  always @(negedge clk) begin
    gen_cnt = gen_cnt + 1;
    if (pat_mode == 0) in_pkt = 32'h0100_0000 + gen_cnt;
    else               in_pkt = (gen_cnt * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  end

  // reference model: pushes one expected item per read edge
  logic [31:0] hist [0:4095];
  logic        qv[$];
  logic [31:0] qd[$];
  string       qt[$];
  int e_idx = 0;
  int m_dly = 1, m_pend = 1;
  bit m_pend_v = 0;

  always @(posedge clk) begin
    if (rst) begin
      e_idx = 0; m_dly = 1; m_pend = 1; m_pend_v = 0;
      qv.delete(); qd.delete(); qt.delete();
    end else begin
      hist[e_idx] = in_pkt;
      if (e_idx - m_dly >= 0) begin qv.push_back(1'b1); qd.push_back(hist[e_idx - m_dly]); end
      else                    begin qv.push_back(1'b0); qd.push_back('0); end
      qt.push_back(sb_tag);
      if (sync_pulse && m_pend_v) m_dly = m_pend;
      if (dly_load) begin
        if (dly_req > MAXD)     m_pend = MAXD;
        else if (dly_req == 0)  m_pend = 1;
        else                    m_pend = int'(dly_req);
        m_pend_v = 1;
      end else if (sync_pulse) m_pend_v = 0;
      e_idx++;
    end
  end

  // monitor: compares the output of edge j with the read made at edge j-1
  always @(negedge clk) begin
    if (!rst && qv.size() >= 2) begin
      logic ev; logic [31:0] ed; string et;
      ev = qv.pop_front(); ed = qd.pop_front(); et = qt.pop_front();
      compared++;
      if (out_valid !== ev) begin
        mismatched++;
        $display("FAIL %s/R6 out_valid actual=%0b expected=%0b", et, out_valid, ev);
      end else if (ev) begin
        compared++;
        if (out_pkt !== ed) begin
          mismatched++;
          $display("FAIL %s out_pkt actual=%h expected=%h", et, out_pkt, ed);
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input int v, input bit s);
    @(negedge clk);
    dly_req = RW'(v); dly_load = 1; sync_pulse = s;
    @(negedge clk);
    dly_load = 0; sync_pulse = 0;
  endtask

  task automatic do_sync();
    @(negedge clk);
    sync_pulse = 1;
    @(negedge clk);
    sync_pulse = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    tick(4);
    chk("R7 out_valid in reset", int'(out_valid), 0);
    chk("R7 range_err in reset", int'(range_err), 0);
    chk("R7 cur_dly in reset", int'(cur_dly), 1);
    rst = 0;
    tick(1);
    chk("R7 out_valid after reset", int'(out_valid), 0);
    tick(20);                                  // R1 / R6 at delay 1

    do_load(5, 0);
    chk("R2 cur_dly before sync", int'(cur_dly), 1);
    chk("R2 range_err in-range", int'(range_err), 0);
    tick(8);
    chk("R2 cur_dly held without sync", int'(cur_dly), 1);
    sb_tag = "R9";
    do_sync();
    chk("R2 cur_dly after sync", int'(cur_dly), 5);
    tick(6);
    do_sync();
    chk("R3 sync without pending", int'(cur_dly), 5);
    sb_tag = "R1";
    pat_mode = 1;
    tick(10);

    do_load(200, 0);
    chk("R4 range_err on over-range", int'(range_err), 1);
    chk("R4 cur_dly before sync", int'(cur_dly), 5);
    sb_tag = "R6";
    do_sync();
    chk("R4 clamp to max", int'(cur_dly), MAXD);
    tick(80);

    do_load(0, 0);
    chk("R4 range_err on zero", int'(range_err), 1);
    sb_tag = "R9";
    do_sync();
    chk("R4 clamp to one", int'(cur_dly), 1);
    tick(10);

    do_load(10, 0);
    chk("R5 range_err cleared", int'(range_err), 0);
    do_load(7, 1);
    chk("R8 old pending applied", int'(cur_dly), 10);
    tick(3);
    chk("R8 new value still pending", int'(cur_dly), 10);
    do_sync();
    chk("R8 new value applied", int'(cur_dly), 7);
    pat_mode = 0;
    tick(10);

    do_load(MAXD, 0);
    chk("R5 boundary accepted", int'(range_err), 0);
    do_sync();
    chk("R4 boundary value kept", int'(cur_dly), MAXD);
    tick(70);
    do_load(MAXD + 1, 0);
    chk("R4 one over boundary flagged", int'(range_err), 1);
    do_sync();
    chk("R4 one over clamped", int'(cur_dly), MAXD);
    sb_tag = "R1";
    tick(20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule